// File: doc/BRIEF.md
# Three-Wide Rename and In-Order Commit Buffer

This block tracks micro-ops from rename to commit for a core with eight architectural registers. Each cycle up to three micro-ops may ask for a slot in a circular buffer of in-flight results. Each one gets an entry index (its tag). The alias table then records that the micro-op's destination register is waiting on that tag. A source lookup port tells the rename stage one of two things about an architectural register: it holds a committed value in the retirement register file, or it waits on a pending tag. A ready bit shows whether that pending value has already been produced.

Execution units report a result by tag, and may flag the result as faulting (an exception or a branch mispredict). The commit logic looks at the oldest entries. In a single cycle it retires as many consecutive finished, clean entries as it can, up to three. It copies their values into the retirement register file and clears alias mappings that still name them. A faulting entry that reaches the oldest position is not retired. Instead the block raises a flush that empties the buffer and points every register back at committed state.

The allocation port follows valid/ready rules. A slot is taken only in a cycle where its valid bit and `alloc_ready` are both high. When ready is low nothing is taken, and the source keeps its request. Ready depends on occupancy and flush, never on the writeback port.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty, `ret_cnt` and `flush` are 0, and a lookup of any register returns pending 0, ready 1 and value 0.
- R2: Valid slots in a cycle receive consecutive tags in slot order, starting at the oldest free index and wrapping from 39 to 0. Invalid slots are skipped. `alloc_ready` is high exactly when no flush is raised and the free entry count is at least the number of valid slots. While it is low nothing is allocated.
- R3: After an allocation, a lookup of its destination register shows pending 1 and that tag. When two slots in one cycle name the same register, the higher-numbered slot's tag is the one recorded.
- R4: A lookup of a pending register reports ready 1 once its entry has been written back, and then its value is the written data. Before that, ready is 0. A register that is not pending reports ready 1 with its committed value.
- R5: A writeback stores data and a fault flag in the entry named by `wb_tag` and marks it finished.
- R6: `ret_cnt` equals the number of consecutive finished, non-faulted entries counted from the oldest, capped at 3. Entries retire strictly in allocation order.
- R7: Retired values are written into the retirement register file. When several retirements in one cycle target one register, the youngest value remains.
- R8: On retirement a register mapping is cleared only if it still names the retiring tag. A mapping to a younger tag stays pending.
- R9: When the oldest entry is finished and faulted, `flush` is 1, `ret_cnt` is 0 and `alloc_ready` is 0. On the next cycle the buffer is empty, every register reads as not pending, and committed values are unchanged.
- R10: The buffer holds at most 40 entries. With one free entry a two-slot request stalls and a one-slot request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 3 | Per-slot allocation request |
| alloc_dst | input | 9 | Per-slot destination register, 3 bits per slot, slot 0 in bits 2:0 |
| alloc_ready | output | 1 | All valid slots are accepted this cycle |
| alloc_tag | output | 18 | Per-slot assigned tag, 6 bits per slot, slot 0 in bits 5:0 |
| lk_arch | input | 3 | Register to look up |
| lk_pend | output | 1 | Register waits on an in-flight entry |
| lk_ready | output | 1 | Lookup value is available |
| lk_tag | output | 6 | Tag the register waits on |
| lk_value | output | 32 | Committed or produced value |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | 6 | Entry being written back |
| wb_data | input | 32 | Result value |
| wb_fault | input | 1 | Result carries an exception or mispredict |
| ret_cnt | output | 2 | Entries retiring this cycle |
| flush | output | 1 | Oldest entry faulted; buffer is discarded at this edge |

## Verification
Several directed patterns come first. A fill to exactly full shows whether the free count is exact at 39 and 40 entries. Writebacks in reverse order let the oldest entry finish last, which separates three-wide commit from one-at-a-time commit. Two back-to-back writes of one register show whether retirement clears a mapping that a younger tag now owns. A faulting middle entry shows whether commit stops at the faulting entry and the flush follows. A long random run then mixes partial and duplicate-destination allocation, out-of-order writeback and rare faults. Every cycle it compares tags, ready, retire count, flush and lookups against a reference model kept in the bench.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned ROB_DEPTH = 40;
  localparam int unsigned ISSUE_W   = 3;
  localparam int unsigned ARCH_N    = 8;
  localparam int unsigned XLEN      = 32;

  // index arithmetic on a circular buffer of arbitrary depth
  function automatic int unsigned ring_add(input int unsigned base, input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc import rob_pkg::*; #(
  parameter int DEPTH = 40,
  parameter int W     = 3,
  localparam int TW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]    valid,
  input  logic [TW-1:0]   tail,
  input  logic [NW-1:0]   count,
  input  logic            blocked,
  output logic            ready,
  output logic [W*TW-1:0] tags,
  output logic [W-1:0]    fire,
  output logic [CW-1:0]   n_alloc
);
  logic [CW-1:0] need;

  always_comb begin
    int unsigned off;
    need = '0;
    off  = 0;
    for (int i = 0; i < W; i++) begin
      tags[i*TW +: TW] = TW'(ring_add(int'(tail), off, DEPTH));
      if (valid[i]) begin
        need = need + 1'b1;
        off  = off + 1;
      end
    end
    ready   = !blocked && (int'(count) + int'(need) <= DEPTH);
    fire    = valid & {W{ready}};
    n_alloc = ready ? need : '0;
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire import rob_pkg::*; #(
  parameter int DEPTH = 40,
  parameter int W     = 3,
  localparam int TW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(W + 1)
) (
  input  logic [DEPTH-1:0] done,
  input  logic [DEPTH-1:0] fault,
  input  logic [TW-1:0]    head,
  input  logic [NW-1:0]    count,
  output logic [W-1:0]     ret_en,
  output logic [W*TW-1:0]  ret_idx,
  output logic [CW-1:0]    ret_cnt,
  output logic             flush
);
  always_comb begin
    logic go;
    logic [TW-1:0] idx;
    go      = 1'b1;
    ret_en  = '0;
    ret_cnt = '0;
    for (int i = 0; i < W; i++) begin
      idx = TW'(ring_add(int'(head), i, DEPTH));
      ret_idx[i*TW +: TW] = idx;
      if (go && int'(count) > i && done[idx] && !fault[idx]) begin
        ret_en[i] = 1'b1;
        ret_cnt   = ret_cnt + 1'b1;
      end else begin
        go = 1'b0;
      end
    end
    flush = (count != '0) && done[head] && fault[head];
  end
endmodule

// File: rtl/rob_alias.sv
module rob_alias #(
  parameter int DEPTH = 40,
  parameter int W     = 3,
  parameter int ARCH  = 8,
  parameter int XLEN  = 32,
  localparam int TW = $clog2(DEPTH),
  localparam int AW = $clog2(ARCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [W-1:0]      fire,
  input  logic [W*AW-1:0]   fire_dst,
  input  logic [W*TW-1:0]   fire_tag,
  input  logic [W-1:0]      ret_en,
  input  logic [W*TW-1:0]   ret_idx,
  input  logic [W*AW-1:0]   ret_dst,
  input  logic [W*XLEN-1:0] ret_data,
  input  logic [AW-1:0]     lk_arch,
  output logic              lk_pend,
  output logic [TW-1:0]     lk_tag,
  output logic [XLEN-1:0]   lk_commit
);
  logic [ARCH-1:0] pend_q;
  logic [TW-1:0]   tag_q [ARCH];
  logic [XLEN-1:0] rrf_q [ARCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int r = 0; r < ARCH; r++) begin
        tag_q[r] <= '0;
        rrf_q[r] <= '0;
      end
    end else begin
      // slot order: the youngest retiring value lands last
      for (int i = 0; i < W; i++)
        if (ret_en[i]) rrf_q[ret_dst[i*AW +: AW]] <= ret_data[i*XLEN +: XLEN];
      if (flush) begin
        pend_q <= '0;
      end else begin
        for (int i = 0; i < W; i++)
          if (ret_en[i] && pend_q[ret_dst[i*AW +: AW]] &&
              tag_q[ret_dst[i*AW +: AW]] == ret_idx[i*TW +: TW])
            pend_q[ret_dst[i*AW +: AW]] <= 1'b0;
        for (int i = 0; i < W; i++)
          if (fire[i]) begin
            pend_q[fire_dst[i*AW +: AW]] <= 1'b1;
            tag_q[fire_dst[i*AW +: AW]]  <= fire_tag[i*TW +: TW];
          end
      end
    end
  end

  assign lk_pend   = pend_q[lk_arch];
  assign lk_tag    = tag_q[lk_arch];
  assign lk_commit = rrf_q[lk_arch];
endmodule

// File: rtl/rob_rename.sv
module rob_rename import rob_pkg::*; #(
  parameter int DEPTH = ROB_DEPTH,
  parameter int W     = ISSUE_W,
  parameter int ARCH  = ARCH_N,
  parameter int DW    = XLEN,
  localparam int TW = $clog2(DEPTH),
  localparam int AW = $clog2(ARCH),
  localparam int NW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    alloc_valid,
  input  logic [W*AW-1:0] alloc_dst,
  output logic            alloc_ready,
  output logic [W*TW-1:0] alloc_tag,
  input  logic [AW-1:0]   lk_arch,
  output logic            lk_pend,
  output logic            lk_ready,
  output logic [TW-1:0]   lk_tag,
  output logic [DW-1:0]   lk_value,
  input  logic            wb_valid,
  input  logic [TW-1:0]   wb_tag,
  input  logic [DW-1:0]   wb_data,
  input  logic            wb_fault,
  output logic [CW-1:0]   ret_cnt,
  output logic            flush
);
  logic [TW-1:0]    head_q, tail_q;
  logic [NW-1:0]    count_q;
  logic [DEPTH-1:0] done_q, fault_q;
  logic [DW-1:0]    data_q [DEPTH];
  logic [AW-1:0]    dst_q  [DEPTH];

  logic [W-1:0]    fire, ret_en;
  logic [CW-1:0]   n_alloc;
  logic [W*TW-1:0] ret_idx;
  logic [W*AW-1:0] ret_dst;
  logic [W*DW-1:0] ret_data;
  logic [DW-1:0]   lk_commit;

  rob_alloc #(.DEPTH(DEPTH), .W(W)) u_alloc (
    .valid(alloc_valid), .tail(tail_q), .count(count_q), .blocked(flush),
    .ready(alloc_ready), .tags(alloc_tag), .fire(fire), .n_alloc(n_alloc));

  rob_retire #(.DEPTH(DEPTH), .W(W)) u_retire (
    .done(done_q), .fault(fault_q), .head(head_q), .count(count_q),
    .ret_en(ret_en), .ret_idx(ret_idx), .ret_cnt(ret_cnt), .flush(flush));

  for (genvar g = 0; g < W; g++) begin : g_ret
    assign ret_dst[g*AW +: AW]  = dst_q[ret_idx[g*TW +: TW]];
    assign ret_data[g*DW +: DW] = data_q[ret_idx[g*TW +: TW]];
  end

  rob_alias #(.DEPTH(DEPTH), .W(W), .ARCH(ARCH), .XLEN(DW)) u_alias (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire), .fire_dst(alloc_dst),
    .fire_tag(alloc_tag), .ret_en(ret_en), .ret_idx(ret_idx), .ret_dst(ret_dst),
    .ret_data(ret_data), .lk_arch(lk_arch), .lk_pend(lk_pend), .lk_tag(lk_tag),
    .lk_commit(lk_commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      done_q  <= '0;
      fault_q <= '0;
    end else if (flush) begin
      tail_q  <= head_q;
      count_q <= '0;
      done_q  <= '0;
      fault_q <= '0;
    end else begin
      if (wb_valid) begin
        done_q[wb_tag]  <= 1'b1;
        fault_q[wb_tag] <= wb_fault;
      end
      for (int i = 0; i < W; i++)
        if (fire[i]) begin
          done_q[alloc_tag[i*TW +: TW]]  <= 1'b0;
          fault_q[alloc_tag[i*TW +: TW]] <= 1'b0;
        end
      head_q  <= TW'(ring_add(int'(head_q), int'(ret_cnt), DEPTH));
      tail_q  <= TW'(ring_add(int'(tail_q), int'(n_alloc), DEPTH));
      count_q <= count_q - NW'(ret_cnt) + NW'(n_alloc);
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (!flush) begin
      if (wb_valid) data_q[wb_tag] <= wb_data;
      for (int i = 0; i < W; i++)
        if (fire[i]) dst_q[alloc_tag[i*TW +: TW]] <= alloc_dst[i*AW +: AW];
    end
  end

  assign lk_ready = !lk_pend || done_q[lk_tag];
  assign lk_value = lk_pend ? data_q[lk_tag] : lk_commit;
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int DEPTH = 40,
  parameter int W     = 3,
  localparam int NW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  alloc_valid,
  input logic          alloc_ready,
  input logic          lk_pend,
  input logic          lk_ready,
  input logic [CW-1:0] ret_cnt,
  input logic          flush,
  input logic [NW-1:0] count_q
);
  // R10
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);
  // R10
  full_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count_q) == DEPTH && alloc_valid != '0) |-> !alloc_ready);
  // R9
  flush_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_cnt == '0 && !alloc_ready));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0 && !lk_pend));
  // R4
  committed_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_pend |-> lk_ready);
  // R6
  retire_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ret_cnt) <= W && int'(ret_cnt) <= int'(count_q));
endmodule

bind rob_rename rob_rename_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .lk_pend(lk_pend), .lk_ready(lk_ready), .ret_cnt(ret_cnt), .flush(flush),
  .count_q(count_q));

// File: tb/sim_rob_rename.sv
`timescale 1ns/1ps
module sim_rob_rename;
  localparam int D = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  alloc_valid = '0;
  logic [8:0]  alloc_dst = '0;
  logic        alloc_ready;
  logic [17:0] alloc_tag;
  logic [2:0]  lk_arch = '0;
  logic        lk_pend, lk_ready;
  logic [5:0]  lk_tag;
  logic [31:0] lk_value;
  logic        wb_valid = 1'b0, wb_fault = 1'b0;
  logic [5:0]  wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic [1:0]  ret_cnt;
  logic        flush;

  rob_rename u0 (.*);

  int n_run = 0, n_fail = 0;
  // reference model
  bit m_done[D], m_fault[D];
  logic [31:0] m_data[D];
  int m_dst[D];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit rat_pend[8];
  int rat_tag[8];
  logic [31:0] rrf[8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_retire();
    int r = 0;
    for (int k = 0; k < 3; k++) begin
      int idx = (m_head + k) % D;
      if (k >= m_cnt || !m_done[idx] || m_fault[idx]) break;
      r++;
    end
    return r;
  endfunction

  function automatic bit exp_flush();
    return m_cnt > 0 && m_done[m_head] && m_fault[m_head];
  endfunction

  task automatic step(input logic [2:0] av, input logic [8:0] ad, input bit wv,
                      input int wt, input logic [31:0] wd, input bit wf, input int la);
    int need = 0, off = 0, er;
    bit ef, er_ok;
    alloc_valid = av; alloc_dst = ad; wb_valid = wv; wb_tag = 6'(wt);
    wb_data = wd; wb_fault = wf; lk_arch = 3'(la);
    #1;
    for (int i = 0; i < 3; i++) if (av[i]) need++;
    ef = exp_flush();
    er = exp_retire();
    er_ok = !ef && (m_cnt + need <= D);
    chk(alloc_ready == er_ok, "R2 R10 alloc_ready", alloc_ready, er_ok);
    chk(int'(ret_cnt) == er, "R6 ret_cnt", ret_cnt, er);
    chk(flush == ef, "R9 flush", flush, ef);
    if (er_ok)
      for (int i = 0; i < 3; i++)
        if (av[i]) begin
          chk(int'(alloc_tag[i*6 +: 6]) == (m_tail + off) % D, "R2 tag",
              alloc_tag[i*6 +: 6], (m_tail + off) % D);
          off++;
        end
    chk(lk_pend == rat_pend[la], "R3 lk_pend", lk_pend, rat_pend[la]);
    if (rat_pend[la]) begin
      chk(int'(lk_tag) == rat_tag[la], "R3 lk_tag", lk_tag, rat_tag[la]);
      chk(lk_ready == m_done[rat_tag[la]], "R4 R5 lk_ready", lk_ready, m_done[rat_tag[la]]);
      if (m_done[rat_tag[la]])
        chk(lk_value == m_data[rat_tag[la]], "R4 R5 lk_value", lk_value, m_data[rat_tag[la]]);
    end else begin
      chk(lk_ready == 1'b1, "R4 lk_ready", lk_ready, 1);
      chk(lk_value == rrf[la], "R4 R7 committed value", lk_value, rrf[la]);
    end
    // advance the model across the coming edge
    if (ef) begin
      m_tail = m_head; m_cnt = 0;
      for (int r = 0; r < 8; r++) rat_pend[r] = 0;
      for (int e = 0; e < D; e++) begin m_done[e] = 0; m_fault[e] = 0; end
    end else begin
      for (int k = 0; k < er; k++) begin
        int idx = (m_head + k) % D;
        rrf[m_dst[idx]] = m_data[idx];
        if (rat_pend[m_dst[idx]] && rat_tag[m_dst[idx]] == idx) rat_pend[m_dst[idx]] = 0;
      end
      m_head = (m_head + er) % D;
      m_cnt -= er;
      if (wv) begin m_done[wt] = 1; m_fault[wt] = wf; m_data[wt] = wd; end
      if (er_ok)
        for (int i = 0; i < 3; i++)
          if (av[i]) begin
            m_done[m_tail] = 0; m_fault[m_tail] = 0; m_dst[m_tail] = int'(ad[i*3 +: 3]);
            rat_pend[ad[i*3 +: 3]] = 1; rat_tag[ad[i*3 +: 3]] = m_tail;
            m_tail = (m_tail + 1) % D; m_cnt++;
          end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int la);
    step(3'b000, 9'd0, 0, 0, 32'd0, 0, la);
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4817));
    for (int r = 0; r < 8; r++) begin rat_pend[r] = 0; rat_tag[r] = 0; rrf[r] = '0; end
    for (int e = 0; e < D; e++) begin m_done[e] = 0; m_fault[e] = 0; m_data[e] = '0; m_dst[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state on every register
    for (int r = 0; r < 8; r++) idle(r);
    // R10: fill to 39, then 2 stalls, 1 fits, then full
    for (int s = 0; s < 13; s++) step(3'b111, {3'(s), 3'(s + 1), 3'(s + 2)}, 0, 0, 0, 0, s % 8);
    step(3'b011, 9'o012, 0, 0, 0, 0, 1);
    step(3'b001, 9'o004, 0, 0, 0, 0, 4);
    step(3'b001, 9'o005, 0, 0, 0, 0, 5);
    // R6 R7: reverse writeback so the oldest finishes last, then 3-wide commit
    for (int k = 0; k < D; k++)
      step(3'b000, 0, 1, (m_head + D - 1 - k) % D, $urandom, 0, k % 8);
    while (m_cnt > 0) idle($urandom_range(0, 7));
    // R8: two writers of register 2; retiring the older keeps the younger mapping
    step(3'b001, 9'o002, 0, 0, 0, 0, 2);
    step(3'b001, 9'o002, 0, 0, 0, 0, 2);
    step(3'b000, 0, 1, m_head, 32'h1111_2222, 0, 2);
    idle(2);
    chk(lk_pend == 1'b1, "R8 younger mapping kept", lk_pend, 1);
    chk(int'(lk_tag) == (m_tail + D - 1) % D, "R8 younger tag", lk_tag, (m_tail + D - 1) % D);
    step(3'b000, 0, 1, (m_tail + D - 1) % D, 32'h3333_4444, 0, 2);
    while (m_cnt > 0) idle(2);
    chk(lk_value == 32'h3333_4444, "R7 R8 final value", lk_value, 32'h3333_4444);
    // R3: duplicate destination inside one group
    step(3'b111, 9'o555, 0, 0, 0, 0, 5);
    idle(5);
    // R9: middle entry faults; oldest retires, then flush
    step(3'b000, 0, 1, (m_head + 1) % D, 32'hdead, 1, 5);
    step(3'b000, 0, 1, m_head, 32'h77, 0, 5);
    idle(5);
    idle(5);
    chk(lk_pend == 1'b0 && lk_value == 32'h77, "R9 committed after flush", lk_value, 32'h77);
    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [2:0] av = 3'($urandom_range(0, 7));
      bit wv = 0; int wt = 0; bit wf = 0;
      if (m_cnt > 0 && $urandom_range(0, 3) != 0) begin
        int o = $urandom_range(0, m_cnt - 1);
        wt = (m_head + o) % D;
        if (!m_done[wt]) begin wv = 1; wf = ($urandom_range(0, 59) == 0); end
      end
      step(av, 9'($urandom), wv, wt, $urandom, wf, $urandom_range(0, 7));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule